// File: doc/BRIEF.md
# Interrupt Event Translation Engine

This block turns a message-signalled interrupt, named by a device number and an event number, into a pending request for one CPU. Requests arrive one at a time over a valid/ready handshake. A request comes either from a queued command (raise, clear or discard) or from a doorbell write. For a doorbell, the device number is the requester identity of the write and the event number is its data. The block does not decode either of these sources itself. It only sees the request kind and the two numbers.

For each request a single sequencer walks three tables in memory through one shared table port. The device table gives the base address of the device's translation table and its event range. The translation entry gives the interrupt number and a collection number. The collection table gives the target CPU. Each step is bounds-checked. A request that fails any check is dropped quietly: it gives no pending request and no bus error, and its completion pulse carries the error flag.

When all checks pass, the block issues one pending request made of CPU number, interrupt number and level. The level is set for raise and doorbell, and clear for clear and discard. A discard then overwrites the translation entry with zeros so that the event is no longer mapped.

Top module: `event_xlate_engine`

## Requirements
- R1: `req_ready` is high only while the engine is idle. A request is accepted on a cycle with `req_valid` and `req_ready` both high. Each accepted request produces exactly one `done` pulse, with `done_err` high when the request was dropped.
- R2: A device number above `DEV_MAX` is dropped before any table transfer is started.
- R3: The device entry is an 8-byte read at `dev_tbl_base + dev*8`. Bit 0 is the valid flag. Bits 5:1 hold the size field. The translation table base is the entry with its low 8 bits forced to zero. An entry whose valid flag is clear drops the request.
- R4: The request is dropped when the event number is greater than 2^(size+1). An event number equal to that limit is accepted.
- R5: The translation entry is read in two parts: an 8-byte low word at `itt + evt*12`, then a 4-byte high word at `itt + evt*12 + 8`. In the low word, bit 0 is the valid flag, bit 1 is the physical flag, and bits starting at bit 2 hold the interrupt number. The collection number sits in the least significant bits of the high word. If either flag in the low word is clear, the request is dropped.
- R6: The collection entry is an 8-byte read at `coll_tbl_base + coll*8`. Bit 0 is the valid flag and the CPU number starts at bit 1. The request is dropped when the valid flag is clear or when the CPU number is not below `NUM_CPU`.
- R7: Request kind encoding: 0 = doorbell, 1 = raise, 2 = clear, 3 = discard. A request that passes every check gives exactly one one-cycle `pend_valid` pulse carrying the translated CPU number and interrupt number. `pend_level` is 1 for doorbell and raise, and 0 for clear and discard.
- R8: After its pending request, a discard writes zeros to the translation entry. It first writes 8 bytes at the low word address, then 4 bytes at the low word address plus 8. No other kind writes to the tables.
- R9: A table transfer holds `tbl_valid`, `tbl_addr`, `tbl_we` and `tbl_wide` steady until `tbl_ack`. Each `tbl_ack` completes exactly one transfer.
- R10: After reset, `req_ready` is 1 and `pend_valid`, `done` and `tbl_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_kind | input | 2 | 0 doorbell, 1 raise, 2 clear, 3 discard |
| req_dev | input | DEV_W | Device number |
| req_evt | input | EVT_W | Event number |
| dev_tbl_base | input | ADDR_W | Byte address of the device table |
| coll_tbl_base | input | ADDR_W | Byte address of the collection table |
| tbl_valid | output | 1 | Table transfer request |
| tbl_we | output | 1 | Transfer is a write |
| tbl_wide | output | 1 | 1 = 8-byte transfer, 0 = 4-byte transfer |
| tbl_addr | output | ADDR_W | Byte address of the transfer |
| tbl_wdata | output | 64 | Write data |
| tbl_ack | input | 1 | Transfer complete; read data valid |
| tbl_rdata | input | 64 | Read data, little-endian |
| pend_valid | output | 1 | Pending request strobe |
| pend_cpu | output | CPU_W | Target CPU |
| pend_intid | output | INTID_W | Interrupt number |
| pend_level | output | 1 | 1 = set pending, 0 = clear pending |
| done | output | 1 | Request finished |
| done_err | output | 1 | Finished request was dropped |

## Verification
The bench pushes events onto each boundary.

- Event equal to the limit. An event number exactly at 2^(size+1) must translate, and one past it must be dropped after a single table read. An off-by-one in this comparison either loses the last legal event or reads a translation entry outside the table.
- Each drop cause on its own. Every cause is tested separately: device out of range, device invalid, translation entry invalid, translation entry not physical, collection invalid, and CPU number too large. A missed check shows up as a stray pending pulse or as extra table transfers.
- Discard. The bench checks the addresses and widths of both clearing writes and that the erased bytes read back as zero. It then sends a raise on the same event, which must now be dropped. A design that writes at the wrong offset would leave the mapping alive.

// File: rtl/evx_pkg.sv
package evx_pkg;

  typedef enum logic [1:0] {
    KIND_DOORBELL = 2'd0,
    KIND_RAISE    = 2'd1,
    KIND_CLEAR    = 2'd2,
    KIND_DISCARD  = 2'd3
  } evx_kind_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ITE_LO,
    ST_ITE_HI,
    ST_COLL,
    ST_ISSUE,
    ST_WR_LO,
    ST_WR_HI,
    ST_FINISH
  } evx_stage_t;

  localparam int SIZE_FIELD_W = 5;
  localparam int ITT_ALIGN    = 8;  // translation tables sit on 256-byte boundaries

  // Event numbers greater than 2^(size+1) are outside the device's range.
  function automatic logic evt_out_of_range(input logic [31:0] evt,
                                            input logic [SIZE_FIELD_W-1:0] size);
    logic [33:0] lim;
    lim = 34'd1 << (6'(size) + 6'd1);
    return {2'b00, evt} > lim;
  endfunction

  function automatic logic is_fetch_stage(input evx_stage_t st);
    return (st == ST_DEV) || (st == ST_ITE_LO) || (st == ST_ITE_HI) || (st == ST_COLL);
  endfunction

  function automatic logic is_write_stage(input evx_stage_t st);
    return (st == ST_WR_LO) || (st == ST_WR_HI);
  endfunction

endpackage

// File: rtl/evx_addr_gen.sv
module evx_addr_gen
  import evx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEV_W  = 16,
  parameter int EVT_W  = 16,
  parameter int ICID_W = 16
) (
  input  evx_stage_t          stage,
  input  logic [ADDR_W-1:0]   dev_tbl_base,
  input  logic [ADDR_W-1:0]   coll_tbl_base,
  input  logic [DEV_W-1:0]    dev,
  input  logic [EVT_W-1:0]    evt,
  input  logic [ADDR_W-1:0]   itt_base,
  input  logic [ICID_W-1:0]   icid,
  output logic [ADDR_W-1:0]   addr
);

  localparam int DEV_ENTRY_SHIFT  = 3;   // 8-byte device entries
  localparam int COLL_ENTRY_SHIFT = 3;   // 8-byte collection entries
  localparam int ITE_HI_OFFSET    = 8;   // high word follows the 8-byte low word

  logic [ADDR_W-1:0] dev_off;
  logic [ADDR_W-1:0] coll_off;
  logic [ADDR_W-1:0] ite_lo_addr;

  always_comb begin
    dev_off     = ADDR_W'(dev) << DEV_ENTRY_SHIFT;
    coll_off    = ADDR_W'(icid) << COLL_ENTRY_SHIFT;
    // 12-byte stride built from two shifts
    ite_lo_addr = itt_base + (ADDR_W'(evt) << 3) + (ADDR_W'(evt) << 2);
    unique case (stage)
      ST_DEV:               addr = dev_tbl_base + dev_off;
      ST_ITE_LO, ST_WR_LO:  addr = ite_lo_addr;
      ST_ITE_HI, ST_WR_HI:  addr = ite_lo_addr + ADDR_W'(ITE_HI_OFFSET);
      ST_COLL:              addr = coll_tbl_base + coll_off;
      default:              addr = '0;
    endcase
  end

endmodule

// File: rtl/evx_seq.sv
module evx_seq
  import evx_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEV_W   = 16,
  parameter int EVT_W   = 16,
  parameter int INTID_W = 16,
  parameter int ICID_W  = 16,
  parameter int CPU_W   = 4,
  parameter int NUM_CPU = 4,
  parameter int DEV_MAX = 255
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [DEV_W-1:0]    req_dev,
  input  logic [EVT_W-1:0]    req_evt,
  input  logic                tbl_ack,
  input  logic [63:0]         tbl_rdata,
  output evx_stage_t          stage,
  output logic                tbl_valid,
  output logic                tbl_we,
  output logic                tbl_wide,
  output logic [DEV_W-1:0]    dev_q,
  output logic [EVT_W-1:0]    evt_q,
  output logic [ADDR_W-1:0]   itt_q,
  output logic [ICID_W-1:0]   icid_q,
  output logic [CPU_W-1:0]    cpu_q,
  output logic [INTID_W-1:0]  intid_q,
  output evx_kind_t           kind_q,
  output logic                err_q,
  output logic                issue_stb,
  output logic                finish_stb
);

  localparam logic [DEV_W-1:0] DEV_LIM  = DEV_W'(DEV_MAX);
  localparam logic [CPU_W:0]   CPU_LIM  = (CPU_W+1)'(NUM_CPU);
  localparam int               INTID_LSB = 2;

  evx_stage_t st_q;
  evx_stage_t st_d;

  logic                    dte_ok;
  logic                    ite_ok;
  logic                    cte_ok;
  logic [SIZE_FIELD_W-1:0] dte_size;
  logic [CPU_W-1:0]        cte_cpu;

  always_comb begin
    dte_size = tbl_rdata[SIZE_FIELD_W:1];
    cte_cpu  = tbl_rdata[CPU_W:1];
    dte_ok   = tbl_rdata[0] && !evt_out_of_range(32'(evt_q), dte_size);
    ite_ok   = tbl_rdata[0] && tbl_rdata[1];
    cte_ok   = tbl_rdata[0] && ({1'b0, cte_cpu} < CPU_LIM);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_valid) st_d = (req_dev > DEV_LIM) ? ST_FINISH : ST_DEV;
      ST_DEV:    if (tbl_ack) st_d = dte_ok ? ST_ITE_LO : ST_FINISH;
      ST_ITE_LO: if (tbl_ack) st_d = ite_ok ? ST_ITE_HI : ST_FINISH;
      ST_ITE_HI: if (tbl_ack) st_d = ST_COLL;
      ST_COLL:   if (tbl_ack) st_d = cte_ok ? ST_ISSUE : ST_FINISH;
      ST_ISSUE:  st_d = (kind_q == KIND_DISCARD) ? ST_WR_LO : ST_FINISH;
      ST_WR_LO:  if (tbl_ack) st_d = ST_WR_HI;
      ST_WR_HI:  if (tbl_ack) st_d = ST_FINISH;
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      dev_q   <= '0;
      evt_q   <= '0;
      itt_q   <= '0;
      icid_q  <= '0;
      cpu_q   <= '0;
      intid_q <= '0;
      kind_q  <= KIND_DOORBELL;
      err_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          dev_q  <= req_dev;
          evt_q  <= req_evt;
          kind_q <= evx_kind_t'(req_kind);
          err_q  <= (req_dev > DEV_LIM);
        end
        ST_DEV: if (tbl_ack) begin
          itt_q <= {tbl_rdata[ADDR_W-1:ITT_ALIGN], {ITT_ALIGN{1'b0}}};
          if (!dte_ok) err_q <= 1'b1;
        end
        ST_ITE_LO: if (tbl_ack) begin
          intid_q <= tbl_rdata[INTID_LSB +: INTID_W];
          if (!ite_ok) err_q <= 1'b1;
        end
        ST_ITE_HI: if (tbl_ack) icid_q <= tbl_rdata[ICID_W-1:0];
        ST_COLL: if (tbl_ack) begin
          cpu_q <= cte_cpu;
          if (!cte_ok) err_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stage      = st_q;
    req_ready  = (st_q == ST_IDLE);
    tbl_valid  = is_fetch_stage(st_q) || is_write_stage(st_q);
    tbl_we     = is_write_stage(st_q);
    tbl_wide   = (st_q == ST_DEV) || (st_q == ST_ITE_LO) || (st_q == ST_COLL) || (st_q == ST_WR_LO);
    issue_stb  = (st_q == ST_ISSUE);
    finish_stb = (st_q == ST_FINISH);
  end

  // R9: a started transfer keeps its shape until acknowledged
  assert_xfer_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (tbl_valid && !tbl_ack) |=> (tbl_valid && $stable(tbl_we) && $stable(tbl_wide) && $stable(st_q)));

  // R2: no table walk starts for a device number out of range
  assert_dev_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DEV) |-> (dev_q <= DEV_LIM));

  // R8: only a discard ever writes the tables
  assert_write_only_discard_R8: assert property (@(posedge clk) disable iff (rst)
    (tbl_valid && tbl_we) |-> (kind_q == KIND_DISCARD));

endmodule

// File: rtl/evx_pend_reg.sv
module evx_pend_reg
  import evx_pkg::*;
#(
  parameter int INTID_W = 16,
  parameter int CPU_W   = 4,
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue_stb,
  input  logic               finish_stb,
  input  logic               err,
  input  evx_kind_t          kind,
  input  logic [CPU_W-1:0]   cpu,
  input  logic [INTID_W-1:0] intid,
  output logic               pend_valid,
  output logic [CPU_W-1:0]   pend_cpu,
  output logic [INTID_W-1:0] pend_intid,
  output logic               pend_level,
  output logic               done,
  output logic               done_err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_cpu   <= '0;
      pend_intid <= '0;
      pend_level <= 1'b0;
      done       <= 1'b0;
      done_err   <= 1'b0;
    end else begin
      pend_valid <= issue_stb;
      done       <= finish_stb;
      done_err   <= finish_stb && err;
      if (issue_stb) begin
        pend_cpu   <= cpu;
        pend_intid <= intid;
        pend_level <= (kind == KIND_DOORBELL) || (kind == KIND_RAISE);
      end
    end
  end

  // R7: a pending request is a single-cycle strobe
  assert_pend_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    pend_valid |=> !pend_valid);

  // R6: issued CPU numbers are always below the CPU count
  assert_cpu_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    pend_valid |-> (32'(pend_cpu) < NUM_CPU));

  // R1: completion is a single-cycle strobe
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/event_xlate_engine.sv
module event_xlate_engine
  import evx_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEV_W   = 16,
  parameter int EVT_W   = 16,
  parameter int INTID_W = 16,
  parameter int ICID_W  = 16,
  parameter int CPU_W   = 4,
  parameter int NUM_CPU = 4,
  parameter int DEV_MAX = 255
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic [DEV_W-1:0]   req_dev,
  input  logic [EVT_W-1:0]   req_evt,
  input  logic [ADDR_W-1:0]  dev_tbl_base,
  input  logic [ADDR_W-1:0]  coll_tbl_base,
  output logic               tbl_valid,
  output logic               tbl_we,
  output logic               tbl_wide,
  output logic [ADDR_W-1:0]  tbl_addr,
  output logic [63:0]        tbl_wdata,
  input  logic               tbl_ack,
  input  logic [63:0]        tbl_rdata,
  output logic               pend_valid,
  output logic [CPU_W-1:0]   pend_cpu,
  output logic [INTID_W-1:0] pend_intid,
  output logic               pend_level,
  output logic               done,
  output logic               done_err
);

  evx_stage_t         stage;
  logic [DEV_W-1:0]   dev_q;
  logic [EVT_W-1:0]   evt_q;
  logic [ADDR_W-1:0]  itt_q;
  logic [ICID_W-1:0]  icid_q;
  logic [CPU_W-1:0]   cpu_q;
  logic [INTID_W-1:0] intid_q;
  evx_kind_t          kind_q;
  logic               err_q;
  logic               issue_stb;
  logic               finish_stb;

  evx_seq #(
    .ADDR_W(ADDR_W), .DEV_W(DEV_W), .EVT_W(EVT_W), .INTID_W(INTID_W),
    .ICID_W(ICID_W), .CPU_W(CPU_W), .NUM_CPU(NUM_CPU), .DEV_MAX(DEV_MAX)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_dev(req_dev), .req_evt(req_evt),
    .tbl_ack(tbl_ack), .tbl_rdata(tbl_rdata),
    .stage(stage), .tbl_valid(tbl_valid), .tbl_we(tbl_we), .tbl_wide(tbl_wide),
    .dev_q(dev_q), .evt_q(evt_q), .itt_q(itt_q), .icid_q(icid_q),
    .cpu_q(cpu_q), .intid_q(intid_q), .kind_q(kind_q), .err_q(err_q),
    .issue_stb(issue_stb), .finish_stb(finish_stb)
  );

  evx_addr_gen #(
    .ADDR_W(ADDR_W), .DEV_W(DEV_W), .EVT_W(EVT_W), .ICID_W(ICID_W)
  ) u_addr (
    .stage(stage), .dev_tbl_base(dev_tbl_base), .coll_tbl_base(coll_tbl_base),
    .dev(dev_q), .evt(evt_q), .itt_base(itt_q), .icid(icid_q), .addr(tbl_addr)
  );

  evx_pend_reg #(
    .INTID_W(INTID_W), .CPU_W(CPU_W), .NUM_CPU(NUM_CPU)
  ) u_pend (
    .clk(clk), .rst(rst),
    .issue_stb(issue_stb), .finish_stb(finish_stb), .err(err_q), .kind(kind_q),
    .cpu(cpu_q), .intid(intid_q),
    .pend_valid(pend_valid), .pend_cpu(pend_cpu), .pend_intid(pend_intid),
    .pend_level(pend_level), .done(done), .done_err(done_err)
  );

  // An erased entry is all zeros; this is the only data ever written.
  assign tbl_wdata = '0;

  // R1: while a request is in flight no new one is taken
  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (rst)
    tbl_valid |-> !req_ready);

  // R7: a pending strobe never coincides with an error completion
  assert_no_pend_on_error_R7: assert property (@(posedge clk) disable iff (rst)
    (done && done_err) |-> !pend_valid);

endmodule

// File: tb/event_xlate_engine_tb.sv
module event_xlate_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 4096;
  localparam logic [1:0] K_DB = 2'd0, K_RAISE = 2'd1, K_CLEAR = 2'd2, K_DISCARD = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_dev = '0;
  logic [15:0] req_evt = '0;
  logic [31:0] dev_tbl_base  = 32'h000;
  logic [31:0] coll_tbl_base = 32'h100;
  logic        tbl_valid, tbl_we, tbl_wide;
  logic [31:0] tbl_addr;
  logic [63:0] tbl_wdata;
  logic        tbl_ack = 1'b0;
  logic [63:0] tbl_rdata = '0;
  logic        pend_valid;
  logic [3:0]  pend_cpu;
  logic [15:0] pend_intid;
  logic        pend_level;
  logic        done, done_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  event_xlate_engine u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_dev(req_dev), .req_evt(req_evt),
    .dev_tbl_base(dev_tbl_base), .coll_tbl_base(coll_tbl_base),
    .tbl_valid(tbl_valid), .tbl_we(tbl_we), .tbl_wide(tbl_wide),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .tbl_ack(tbl_ack), .tbl_rdata(tbl_rdata),
    .pend_valid(pend_valid), .pend_cpu(pend_cpu), .pend_intid(pend_intid),
    .pend_level(pend_level), .done(done), .done_err(done_err)
  );

  logic [7:0] mem [MEM_BYTES];
  int xfer_cnt, wr_cnt, pend_cnt, done_cnt;
  logic [31:0] wr_addr [2];
  logic        wr_wide [2];
  logic [3:0]  last_cpu;
  logic [15:0] last_intid;
  logic        last_level;
  int checks = 0, fails = 0;
  bit finished = 0;

  // table memory model: acknowledges one cycle after a request is seen
  always @(posedge clk) begin
    if (tbl_valid && !tbl_ack) begin
      tbl_ack <= 1'b1;
      xfer_cnt++;
      if (tbl_we) begin
        for (int b = 0; b < (tbl_wide ? 8 : 4); b++)
          mem[(tbl_addr + 32'(b)) % MEM_BYTES] <= tbl_wdata[8*b +: 8];
        if (wr_cnt < 2) begin
          wr_addr[wr_cnt] <= tbl_addr;
          wr_wide[wr_cnt] <= tbl_wide;
        end
        wr_cnt++;
      end else begin
        logic [63:0] v;
        v = '0;
        for (int b = 0; b < (tbl_wide ? 8 : 4); b++)
          v[8*b +: 8] = mem[(tbl_addr + 32'(b)) % MEM_BYTES];
        tbl_rdata <= v;
      end
    end else begin
      tbl_ack <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!rst && pend_valid) begin
      pend_cnt++;
      last_cpu   = pend_cpu;
      last_intid = pend_intid;
      last_level = pend_level;
    end
    if (!rst && done) done_cnt++;
  end

  task automatic put(input int addr, input logic [63:0] v, input int nbytes);
    for (int b = 0; b < nbytes; b++) mem[addr + b] = v[8*b +: 8];
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic last_err;

  task automatic run_req(input logic [1:0] kind, input int dev, input int evt);
    xfer_cnt = 0; wr_cnt = 0; pend_cnt = 0; done_cnt = 0;
    @(negedge clk);
    req_kind = kind; req_dev = 16'(dev); req_evt = 16'(evt); req_valid = 1'b1;
    do @(posedge clk); while (!req_ready);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", {63'b0, req_ready}, 64'd0, "ready while busy");
    do @(negedge clk); while (!done);
    last_err = done_err;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_ok(input string req, input logic [3:0] cpu, input int intid, input logic lvl);
    check(req, {63'b0, last_err}, 64'd0, "error flag");
    check(req, 64'(pend_cnt), 64'd1, "pending pulses");
    check(req, 64'(last_cpu), 64'(cpu), "cpu");
    check(req, 64'(last_intid), 64'(intid), "intid");
    check(req, 64'(last_level), 64'(lvl), "level");
    check("R1", 64'(done_cnt), 64'd1, "done pulses");
  endtask

  task automatic expect_drop(input string req, input int xfers);
    check(req, {63'b0, last_err}, 64'd1, "error flag");
    check(req, 64'(pend_cnt), 64'd0, "pending pulses");
    check(req, 64'(xfer_cnt), 64'(xfers), "table transfers");
    check("R1", 64'(done_cnt), 64'd1, "done pulses");
  endtask

  function automatic logic [63:0] ite_lo(input int intid, input bit v, input bit phys);
    return (64'(intid) << 2) | (64'(phys) << 1) | 64'(v);
  endfunction

  task automatic t_reset();
    check("R10", {63'b0, req_ready}, 64'd1, "ready after reset");
    check("R10", {63'b0, pend_valid}, 64'd0, "pend after reset");
    check("R10", {63'b0, done}, 64'd0, "done after reset");
    check("R10", {63'b0, tbl_valid}, 64'd0, "tbl_valid after reset");
  endtask

  task automatic t_raise_and_kinds();
    run_req(K_RAISE, 0, 3);
    expect_ok("R7", 4'd2, 8200, 1'b1);
    check("R5", 64'(xfer_cnt), 64'd4, "reads for full walk (R3 R6)");
    check("R8", 64'(wr_cnt), 64'd0, "raise writes nothing");
    run_req(K_DB, 0, 3);
    expect_ok("R7", 4'd2, 8200, 1'b1);
    run_req(K_CLEAR, 0, 3);
    expect_ok("R7", 4'd2, 8200, 1'b0);
    check("R8", 64'(wr_cnt), 64'd0, "clear writes nothing");
  endtask

  task automatic t_event_bounds();
    run_req(K_RAISE, 0, 8);
    expect_ok("R4", 4'd3, 8300, 1'b1);
    run_req(K_RAISE, 0, 9);
    expect_drop("R4", 1);
  endtask

  task automatic t_device_drops();
    run_req(K_RAISE, 300, 0);
    expect_drop("R2", 0);
    run_req(K_RAISE, 1, 0);
    expect_drop("R3", 1);
  endtask

  task automatic t_entry_drops();
    run_req(K_RAISE, 0, 5);
    expect_drop("R5", 2);
    run_req(K_RAISE, 0, 6);
    expect_drop("R5", 2);
    run_req(K_RAISE, 0, 7);
    expect_drop("R6", 4);
    run_req(K_RAISE, 0, 4);
    expect_drop("R6", 4);
  endtask

  task automatic t_discard();
    logic [63:0] v;
    run_req(K_DISCARD, 2, 2);
    expect_ok("R8", 4'd2, 9000, 1'b0);
    check("R8", 64'(wr_cnt), 64'd2, "discard writes");
    check("R8", 64'(wr_addr[0]), 64'h818, "first write address");
    check("R8", 64'(wr_wide[0]), 64'd1, "first write width");
    check("R8", 64'(wr_addr[1]), 64'h820, "second write address");
    check("R8", 64'(wr_wide[1]), 64'd0, "second write width");
    v = '0;
    for (int b = 0; b < 12; b++) v = v | 64'(mem[32'h818 + b]);
    check("R8", v, 64'd0, "erased entry bytes");
    run_req(K_RAISE, 2, 2);
    expect_drop("R8", 2);
  endtask

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'h00;
    // device 0: valid, size 2 (limit 8), ITT at 0x400; device 1 invalid; device 2: size 0, ITT at 0x800
    put(32'h000, 64'h405, 8);
    put(32'h010, 64'h801, 8);
    // device 0 events
    put(32'h400 + 3*12, ite_lo(8200, 1, 1), 8); put(32'h400 + 3*12 + 8, 64'd1, 4);
    put(32'h400 + 8*12, ite_lo(8300, 1, 1), 8); put(32'h400 + 8*12 + 8, 64'd2, 4);
    put(32'h400 + 6*12, ite_lo(8400, 1, 0), 8); put(32'h400 + 6*12 + 8, 64'd1, 4);
    put(32'h400 + 7*12, ite_lo(8500, 1, 1), 8); put(32'h400 + 7*12 + 8, 64'd3, 4);
    put(32'h400 + 4*12, ite_lo(8600, 1, 1), 8); put(32'h400 + 4*12 + 8, 64'd4, 4);
    // device 2 event 2 (equal to its limit)
    put(32'h800 + 2*12, ite_lo(9000, 1, 1), 8); put(32'h800 + 2*12 + 8, 64'd1, 4);
    // collections: 1 -> cpu 2, 2 -> cpu 3, 3 -> cpu 5 (too large), 4 invalid
    put(32'h108, 64'h5, 8);
    put(32'h110, 64'h7, 8);
    put(32'h118, 64'hB, 8);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_raise_and_kinds();
    t_event_bounds();
    t_device_drops();
    t_entry_drops();
    t_discard();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule